// File: doc/BRIEF.md
# Boot Device Failover Watchdog

This block decides which of two boot devices is mapped into the processor's boot region after power-on. By default the processor boots from the on-card soldered flash. A hardware countdown starts when the power-on reset is released. If boot software does not stop the countdown in time, the block assumes the default image is corrupt. It then pulses the processor reset and moves the boot select to a redundant image held in another flash bank. It also raises a sticky flag that only a power cycle clears.

Boot software stops the countdown with a single-cycle write strobe. When a development card is fitted, failover is turned off. A jumper input alone then picks the boot device, and the countdown never resets the processor. Software reads a three-bit status word that gives the failover flag, the live boot select and whether the countdown was stopped. The presence and jumper inputs come from off-board contacts, so each one passes through a resynchronizer of parameterised depth.

Top module: `boot_failover_wdog`

## Requirements
- R1: After power-on reset is released, `cpu_rst` is 0, `boot_alt` is 0 (soldered flash) and `stat` is 3'b000.
- R2: With no card fitted and no stop strobe, `cpu_rst` rises on exactly the `EXPIRE_CYCLES`-th rising clock edge after power-on reset is released.
- R3: `cpu_rst` stays high for exactly `HOLD_CYCLES` edges and then falls. The countdown then runs again from zero, so the next expiry comes `EXPIRE_CYCLES` edges after the release.
- R4: On the first expiry, `boot_alt` changes to 1 (alternate image) in the same cycle that `cpu_rst` rises, and status bit 0 is set.
- R5: Later expiries pulse `cpu_rst` again but leave `boot_alt` at 1. There is never a switch back to the default device.
- R6: A one-cycle `sw_stop` strobe, taken while the countdown runs, stops it. No `cpu_rst` pulse follows until the next power-on reset, and status bit 2 reads 1 from then on.
- R7: A `sw_stop` strobe taken while `cpu_rst` is high has no effect. Status bit 2 stays 0 and the countdown expires again.
- R8: The failover flag and the stopped state are cleared only by `por_n`. Nothing else clears them.
- R9: With `card_present` high, `boot_alt` follows `jumper_alt`, status bit 0 stays 0, and `cpu_rst` never rises.
- R10: Status bit layout: bit 0 is the failover flag, bit 1 is the current boot select (equal to `boot_alt`), and bit 2 is the stopped state.
- R11: `card_present` and `jumper_alt` each pass through `SYNC_STAGES` flip-flops. A change at the input reaches `boot_alt` after `SYNC_STAGES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| card_present | input | 1 | Development card fitted (asynchronous) |
| jumper_alt | input | 1 | Boot jumper, 1 selects the alternate device (asynchronous) |
| sw_stop | input | 1 | Single-cycle strobe that stops the countdown |
| cpu_rst | output | 1 | Processor reset request, active high |
| boot_alt | output | 1 | Boot device select, 0 soldered flash, 1 alternate image |
| stat | output | 3 | Status word: {stopped, boot select, failover flag} |

## Verification
The hardest case to reach is a stop strobe that arrives while the block holds the processor in reset. The strobe has to land inside the few cycles of the hold window. The stimulus counts edges from power-on release and fires the strobe one cycle after the expected expiry. It then shows that status bit 2 stays clear and that a second expiry still comes. The second expiry, and the sticky flag surviving until a power cycle, are checked by running through two full reset pulses and then dropping `por_n`.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

   typedef enum logic [1:0] {
      WD_RUN  = 2'd0,
      WD_HOLD = 2'd1,
      WD_STOP = 2'd2
   } wd_state_e;

   localparam int STAT_W        = 3;
   localparam int STAT_FAIL_BIT = 0;
   localparam int STAT_SEL_BIT  = 1;
   localparam int STAT_STOP_BIT = 2;

endpackage

// File: rtl/bfw_sync.sv
module bfw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         initial $error("bfw_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], d_async} ;
         end
         assign q_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bfw_timer.sv
module bfw_timer
   import bfw_pkg::*;
#(
   parameter int EXPIRE_CYCLES = 1000,
   parameter int HOLD_CYCLES   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic stop_stb,
   output logic expire,
   output logic rst_req,
   output logic stopped
);

   localparam int MAX_SPAN = (EXPIRE_CYCLES > HOLD_CYCLES) ? EXPIRE_CYCLES : HOLD_CYCLES;
   localparam int CNT_W    = $clog2(MAX_SPAN + 1);
   localparam logic [CNT_W-1:0] EXP_LAST  = CNT_W'(EXPIRE_CYCLES - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

   generate
      if (EXPIRE_CYCLES < 2) begin : g_bad_expire
         initial $error("bfw_timer: EXPIRE_CYCLES must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         initial $error("bfw_timer: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   wd_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      expire = (state_q == WD_RUN) && !stop_stb && arm && (cnt_q == EXP_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WD_RUN;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            WD_RUN: begin
               if (stop_stb) begin
                  state_q <= WD_STOP;
                  cnt_q   <= '0;
               end else if (!arm) begin
                  cnt_q <= '0;
               end else if (cnt_q == EXP_LAST) begin
                  state_q <= WD_HOLD;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            WD_HOLD: begin
               if (cnt_q == HOLD_LAST) begin
                  state_q <= WD_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            WD_STOP: begin
               state_q <= WD_STOP;
               cnt_q   <= '0;
            end
            default: begin
               state_q <= WD_RUN;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign rst_req = (state_q == WD_HOLD);
   assign stopped = (state_q == WD_STOP);

   // R7
   stop_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !stopped) |=> !stopped);

   // R6
   no_reset_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !rst_req) |=> !rst_req);

endmodule

// File: rtl/bfw_select.sv
module bfw_select (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic card_s,
   input  logic jumper_s,
   output logic failed_over,
   output logic boot_alt
);

   logic fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fail_q <= 1'b0;
      else if (expire) fail_q <= 1'b1;
   end

   assign failed_over = fail_q;
   assign boot_alt    = card_s ? jumper_s : fail_q;

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |=> fail_q);

   // R5
   no_switch_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_s && fail_q) |=> (card_s || boot_alt));

endmodule

// File: rtl/boot_failover_wdog.sv
module boot_failover_wdog
   import bfw_pkg::*;
#(
   parameter int EXPIRE_CYCLES = 1000,
   parameter int HOLD_CYCLES   = 16,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              card_present,
   input  logic              jumper_alt,
   input  logic              sw_stop,
   output logic              cpu_rst,
   output logic              boot_alt,
   output logic [STAT_W-1:0] stat
);

   generate
      if (EXPIRE_CYCLES <= SYNC_STAGES + 1) begin : g_bad_ratio
         initial $error("boot_failover_wdog: EXPIRE_CYCLES must exceed SYNC_STAGES + 1");
      end
   endgenerate

   logic card_s;
   logic jumper_s;
   logic expire;
   logic stopped;
   logic failed_over;

   bfw_sync #(.STAGES(SYNC_STAGES)) u_card_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .d_async (card_present),
      .q_sync  (card_s)
   );

   bfw_sync #(.STAGES(SYNC_STAGES)) u_jumper_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .d_async (jumper_alt),
      .q_sync  (jumper_s)
   );

   bfw_timer #(
      .EXPIRE_CYCLES (EXPIRE_CYCLES),
      .HOLD_CYCLES   (HOLD_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (por_n),
      .arm      (!card_s),
      .stop_stb (sw_stop),
      .expire   (expire),
      .rst_req  (cpu_rst),
      .stopped  (stopped)
   );

   bfw_select u_select (
      .clk         (clk),
      .rst_n       (por_n),
      .expire      (expire),
      .card_s      (card_s),
      .jumper_s    (jumper_s),
      .failed_over (failed_over),
      .boot_alt    (boot_alt)
   );

   always_comb begin
      stat                = '0;
      stat[STAT_FAIL_BIT] = failed_over;
      stat[STAT_SEL_BIT]  = boot_alt;
      stat[STAT_STOP_BIT] = stopped;
   end

   // R4
   flag_with_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cpu_rst) |-> (failed_over && boot_alt));

   // R9
   card_blocks_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
      (card_s && $past(card_s) && !cpu_rst) |=> !cpu_rst);

   // R9
   card_no_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
      (card_s && !failed_over) |=> !failed_over);

endmodule

// File: tb/boot_failover_wdog_bench.sv
module boot_failover_wdog_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TO   = 40;
   localparam int HOLD = 5;
   localparam int SYNC = 2;

   typedef struct {
      int          cyc;
      logic        rst;
      logic [2:0]  st;
      string       tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       card_present = 1'b0;
   logic       jumper_alt = 1'b0;
   logic       sw_stop = 1'b0;
   logic       cpu_rst;
   logic       boot_alt;
   logic [2:0] stat;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   exp_t sb[$];

   boot_failover_wdog #(
      .EXPIRE_CYCLES (TO),
      .HOLD_CYCLES   (HOLD),
      .SYNC_STAGES   (SYNC)
   ) u_boot_failover_wdog (
      .clk          (clk),
      .por_n        (por_n),
      .card_present (card_present),
      .jumper_alt   (jumper_alt),
      .sw_stop      (sw_stop),
      .cpu_rst      (cpu_rst),
      .boot_alt     (boot_alt),
      .stat         (stat)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic compare(input logic r, input logic [2:0] s, input string tag);
      n_chk++;
      if (cpu_rst !== r || stat !== s || boot_alt !== s[1]) begin
         n_bad++;
         $display("FAIL %s @%0d: rst=%b stat=%b sel=%b expected rst=%b stat=%b sel=%b",
                  tag, cyc, cpu_rst, stat, boot_alt, r, s, s[1]);
      end
   endtask

   task automatic push(input int c, input logic r, input logic [2:0] s, input string tag);
      exp_t e;
      e.cyc = c; e.rst = r; e.st = s; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: pops scoreboard items whose cycle has come
   always @(negedge clk) begin : monitor
      exp_t it;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         it = sb.pop_front();
         if (it.cyc < cyc) begin
            n_chk++; n_bad++;
            $display("FAIL %s: item for cycle %0d missed, now %0d (actual rst=%b expected rst=%b)",
                     it.tag, it.cyc, cyc, cpu_rst, it.rst);
         end else begin
            compare(it.rst, it.st, it.tag);
         end
      end
   end

   task automatic goto(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic strobe_stop();
      sw_stop = 1'b1;
      @(negedge clk);
      sw_stop = 1'b0;
   endtask

   task automatic power_cycle(output int base, input string tag);
      @(negedge clk);
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      compare(1'b0, 3'b000, tag);
      por_n = 1'b1;
      base = cyc;
   endtask

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung (actual=timeout expected=done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : driver
      int b;
      // Scenario A: no stop, two expiries, late stop, power cycle
      power_cycle(b, "R8_por_low");
      push(b,                   1'b0, 3'b000, "R1_after_release");
      push(b+TO-1,              1'b0, 3'b000, "R2_before_expiry");
      push(b+TO,                1'b1, 3'b011, "R2_R4_R10_expiry");
      push(b+TO+HOLD-1,         1'b1, 3'b011, "R3_hold_last");
      push(b+TO+HOLD,           1'b0, 3'b011, "R3_release");
      push(b+2*TO+HOLD-1,       1'b0, 3'b011, "R3_restart_before");
      push(b+2*TO+HOLD,         1'b1, 3'b011, "R5_second_expiry");
      push(b+2*TO+2*HOLD,       1'b0, 3'b011, "R3_second_release");
      push(b+3*TO+3*HOLD+10,    1'b0, 3'b111, "R6_R10_stopped_on_alt");
      goto(b+2*TO+2*HOLD+3);
      strobe_stop();
      drain();
      // Scenario D: stop strobe during hold window is ignored
      power_cycle(b, "R8_flags_cleared");
      push(b+1,                 1'b0, 3'b000, "R8_after_power_cycle");
      push(b+TO,                1'b1, 3'b011, "R2_expiry_again");
      push(b+TO+HOLD,           1'b0, 3'b011, "R7_stop_ignored");
      push(b+2*TO+HOLD,         1'b1, 3'b011, "R7_still_expires");
      goto(b+TO+1);
      strobe_stop();
      drain();
      // Scenario B: stop strobe before expiry
      power_cycle(b, "R1_por_low_again");
      push(b+12,                1'b0, 3'b100, "R6_stopped");
      push(b+TO+5,              1'b0, 3'b100, "R6_no_expiry");
      push(b+3*TO,              1'b0, 3'b100, "R6_still_quiet");
      goto(b+10);
      strobe_stop();
      drain();
      // Scenario C: development card fitted, jumper picks device
      card_present = 1'b1;
      jumper_alt   = 1'b1;
      power_cycle(b, "R9_por_card");
      push(b+SYNC-1,            1'b0, 3'b000, "R11_jumper_not_through_yet");
      push(b+SYNC,              1'b0, 3'b010, "R11_R9_jumper_alt");
      push(b+TO+HOLD+5,         1'b0, 3'b010, "R9_no_expiry");
      push(b+3*TO,              1'b0, 3'b010, "R9_still_no_expiry");
      goto(b+3*TO+1);
      drain();
      jumper_alt = 1'b0;
      b = cyc;
      push(b+SYNC-1,            1'b0, 3'b010, "R11_delay");
      push(b+SYNC,              1'b0, 3'b000, "R9_jumper_default");
      goto(b+SYNC+2);
      strobe_stop();
      b = cyc;
      push(b+2,                 1'b0, 3'b100, "R9_stop_with_card");
      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule